// File: doc/BRIEF.md
# Byte-Mode Serial Flash Access Sequencer

This block runs single-byte accesses to a serial NOR flash on behalf of a host that writes command codes into it. Three codes are understood: a byte read at the current address, a byte program at the current address, and a status read. Each access is driven as one or two chip-select frames on a four-lane serial bus. The frames use an 8-bit opcode, a 24-bit address on lane 0 and optional dummy cycles. Read data comes back on one, two or four lanes. The host sets the lane mode, the read opcodes, the write byte and the address through a small byte-wide configuration port, then polls the busy bits.

The address register advances by one after every byte read or byte program. A run of commands issued after one address setup therefore walks through consecutive flash bytes. Nothing is accepted until an unlock key has been written.

The serial clock runs at half the system clock. It idles low, and the flash samples lane 0 on its rising edge. Returned data is captured on its falling edge.

Top module: `nor_byte_seq`

## Requirements
- R1: After reset the busy bits, read-data byte and status byte are 0, chip select is high and the serial clock is low.
- R2: Command codes are ignored until 0x30 is written to the key select. Writing any other value to the key select locks the block again.
- R3: Code 0x81 (read), 0x90 (program) and 0x02 (status) start an access. The busy output takes the code ANDed with 0x1F (0x01, 0x10, 0x02) in the cycle after the write and keeps it until completion. Any other code, and any code written while busy is non-zero, is ignored.
- R4: With both read-mode bits and the fast bit clear, a read sends opcode 0x03 and the address, with no dummy cycles, and takes one bit per cycle on lane 1. Busy lasts 82 cycles, and the byte appears on rd_data in the cycle busy clears.
- R5: With the fast bit set (and no lane mode), a read sends the opcode from slot A, the address and 8 dummy cycles, then takes single-lane data. Busy lasts 98 cycles.
- R6: Mode bit 0 selects a dual read: opcode from slot A, 8 dummy cycles, and data over 4 cycles on lanes 1:0, with lane 1 carrying the more significant bit. Busy lasts 90 cycles.
- R7: Mode bit 2 selects a quad read: opcode from slot B, 8 dummy cycles, and data over 2 cycles on lanes 3:0, with higher lanes more significant. Busy lasts 86 cycles. It takes priority over mode bit 0 and the fast bit. Mode bits 1 and 3 have no effect, and the address always goes out on lane 0.
- R8: A status read sends opcode 0x05 and puts the returned byte on stat_data when busy clears after 34 cycles. rd_data and the address are unchanged.
- R9: A program access sends a 0x06 frame, then a separate frame with 0x02, the address and the write byte. Busy lasts 100 cycles.
- R10: After every read or program access the address advances by one, wrapping from 0xFFFFFF to 0. A status read leaves it unchanged.
- R11: The serial clock is high only while chip select is low, and lane output enables are active only inside a frame.
- R12: Configuration select codes are: 0 command, 1 mode, 2 fast bit (bit 0), 3 opcode slot A, 4 opcode slot B, 5 write byte, 6/7/8 address bits 7:0/15:8/23:16, and 9 key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration select code |
| cfg_wdata | input | 8 | Configuration write byte |
| busy | output | 5 | Busy bits of the running command |
| rd_data | output | 8 | Last byte read |
| stat_data | output | 8 | Last status byte read |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
Busy appears one cycle after the command write. It stays for 2N+2 cycles for a frame of N serial clocks: 82, 98, 90, 86 and 34 for the read and status variants, and 100 for a program access. rd_data or stat_data changes in the same cycle that busy clears. The bench holds a behavioural flash and a busy profile for each command. It compares busy on the falling clock edge of every cycle from the write until the expected clear. It reads the result bytes only after that point. Ignored commands are checked with the same per-cycle profile held at zero, and by confirming the result bytes are unchanged.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int ADDR_W    = 24;
    localparam int BYTE_W    = 8;
    localparam int BUSY_W    = 5;
    localparam int OPC_CYC   = 8;
    localparam int TX_W      = OPC_CYC + ADDR_W + BYTE_W;
    localparam int CNT_W     = 6;
    localparam int DUMMY_W   = 4;

    localparam logic [7:0] CODE_PIO_RD = 8'h81;
    localparam logic [7:0] CODE_PIO_WR = 8'h90;
    localparam logic [7:0] CODE_STAT   = 8'h02;
    localparam logic [7:0] UNLOCK_KEY  = 8'h30;

    localparam logic [7:0] OP_PLAIN_RD = 8'h03;
    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_RDSR     = 8'h05;

    localparam logic [3:0] SEL_CMD   = 4'd0;
    localparam logic [3:0] SEL_MODE  = 4'd1;
    localparam logic [3:0] SEL_FAST  = 4'd2;
    localparam logic [3:0] SEL_OPC_A = 4'd3;
    localparam logic [3:0] SEL_OPC_B = 4'd4;
    localparam logic [3:0] SEL_WBYTE = 4'd5;
    localparam logic [3:0] SEL_ADR0  = 4'd6;
    localparam logic [3:0] SEL_ADR1  = 4'd7;
    localparam logic [3:0] SEL_ADR2  = 4'd8;
    localparam logic [3:0] SEL_KEY   = 4'd9;

    typedef enum logic [1:0] {LANE_X1, LANE_X2, LANE_X4} lane_e;

    typedef enum logic [1:0] {F_IDLE, F_CSON, F_SHIFT, F_CSOFF} fstate_e;

    typedef struct packed {
        logic [7:0]         opc;
        logic               use_addr;
        logic [ADDR_W-1:0]  addr;
        logic               use_wbyte;
        logic [BYTE_W-1:0]  wbyte;
        logic [DUMMY_W-1:0] dummy;
        logic               use_rx;
        lane_e              lanes;
    } frame_t;

    function automatic logic is_known_code(logic [7:0] c);
        return (c == CODE_PIO_RD) || (c == CODE_PIO_WR) || (c == CODE_STAT);
    endfunction

    function automatic logic [BUSY_W-1:0] busy_mask(logic [7:0] c);
        return c[BUSY_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] tx_len(frame_t f);
        logic [CNT_W-1:0] n;
        n = CNT_W'(OPC_CYC);
        if (f.use_addr)  n = n + CNT_W'(ADDR_W);
        if (f.use_wbyte) n = n + CNT_W'(BYTE_W);
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] rx_len(frame_t f);
        if (!f.use_rx) return '0;
        case (f.lanes)
            LANE_X2: return CNT_W'(BYTE_W / 2);
            LANE_X4: return CNT_W'(BYTE_W / 4);
            default: return CNT_W'(BYTE_W);
        endcase
    endfunction

endpackage

// File: rtl/nor_seq_regs.sv
module nor_seq_regs
    import nor_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [3:0]        sel,
    input  logic [7:0]        wdata,
    input  logic              incr,
    output logic              dual_rd,
    output logic              quad_rd,
    output logic              fast_rd,
    output logic [7:0]        opc_a,
    output logic [7:0]        opc_b,
    output logic [BYTE_W-1:0] wbyte,
    output logic [ADDR_W-1:0] addr,
    output logic              unlocked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dual_rd  <= 1'b0;
            quad_rd  <= 1'b0;
            fast_rd  <= 1'b0;
            opc_a    <= '0;
            opc_b    <= '0;
            wbyte    <= '0;
            addr     <= '0;
            unlocked <= 1'b0;
        end else begin
            if (we) begin
                case (sel)
                    SEL_MODE: begin
                        dual_rd <= wdata[0];
                        quad_rd <= wdata[2];
                    end
                    SEL_FAST:  fast_rd  <= wdata[0];
                    SEL_OPC_A: opc_a    <= wdata;
                    SEL_OPC_B: opc_b    <= wdata;
                    SEL_WBYTE: wbyte    <= wdata;
                    SEL_ADR0:  addr[7:0]   <= wdata;
                    SEL_ADR1:  addr[15:8]  <= wdata;
                    SEL_ADR2:  addr[23:16] <= wdata;
                    SEL_KEY:   unlocked <= (wdata == UNLOCK_KEY);
                    default: ;
                endcase
            end
            if (incr) addr <= addr + 1'b1;
        end
    end

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
        incr |=> (addr == $past(addr) + 24'd1));

endmodule

// File: rtl/nor_seq_plan.sv
module nor_seq_plan
    import nor_seq_pkg::*;
#(
    parameter int unsigned DUMMY = 8
)(
    input  logic [7:0]        code,
    input  logic              dual_rd,
    input  logic              quad_rd,
    input  logic              fast_rd,
    input  logic [7:0]        opc_a,
    input  logic [7:0]        opc_b,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wbyte,
    output frame_t            first_f,
    output frame_t            second_f,
    output logic              two_frames
);

    localparam logic [DUMMY_W-1:0] DUM = DUMMY_W'(DUMMY);

    frame_t rd_f;

    always_comb begin
        rd_f           = '0;
        rd_f.use_addr  = 1'b1;
        rd_f.addr      = addr;
        rd_f.use_rx    = 1'b1;
        if (quad_rd) begin
            rd_f.opc   = opc_b;
            rd_f.lanes = LANE_X4;
            rd_f.dummy = DUM;
        end else if (dual_rd) begin
            rd_f.opc   = opc_a;
            rd_f.lanes = LANE_X2;
            rd_f.dummy = DUM;
        end else if (fast_rd) begin
            rd_f.opc   = opc_a;
            rd_f.lanes = LANE_X1;
            rd_f.dummy = DUM;
        end else begin
            rd_f.opc   = OP_PLAIN_RD;
            rd_f.lanes = LANE_X1;
            rd_f.dummy = '0;
        end
    end

    always_comb begin
        first_f    = '0;
        second_f   = '0;
        two_frames = 1'b0;
        case (code)
            CODE_PIO_RD: first_f = rd_f;
            CODE_STAT: begin
                first_f.opc    = OP_RDSR;
                first_f.use_rx = 1'b1;
                first_f.lanes  = LANE_X1;
            end
            CODE_PIO_WR: begin
                two_frames         = 1'b1;
                first_f.opc        = OP_WREN;
                second_f.opc       = OP_PROG;
                second_f.use_addr  = 1'b1;
                second_f.addr      = addr;
                second_f.use_wbyte = 1'b1;
                second_f.wbyte     = wbyte;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nor_seq_frame.sv
module nor_seq_frame
    import nor_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_t            desc,
    input  logic [3:0]        io_in,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              done,
    output logic              idle,
    output logic [BYTE_W-1:0] rx_byte
);

    fstate_e          state;
    logic [TX_W-1:0]  tx_sh;
    logic [CNT_W-1:0] cyc, txc, rxf, last;
    logic             half, use_rx;
    lane_e            lanes;

    logic [CNT_W-1:0] d_txc, d_rxf;
    assign d_txc = tx_len(desc);
    assign d_rxf = d_txc + CNT_W'(desc.dummy);

    logic can_load;
    assign can_load = start && (state == F_IDLE || state == F_CSOFF);

    logic [BYTE_W-1:0] rx_next;
    always_comb begin
        case (lanes)
            LANE_X2: rx_next = {rx_byte[BYTE_W-3:0], io_in[1:0]};
            LANE_X4: rx_next = {rx_byte[BYTE_W-5:0], io_in[3:0]};
            default: rx_next = {rx_byte[BYTE_W-2:0], io_in[1]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= F_IDLE;
            tx_sh   <= '0;
            cyc     <= '0;
            txc     <= '0;
            rxf     <= '0;
            last    <= '0;
            half    <= 1'b0;
            use_rx  <= 1'b0;
            lanes   <= LANE_X1;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            rx_byte <= '0;
        end else if (can_load) begin
            if (state == F_CSOFF) cs_n <= 1'b1;
            state   <= F_CSON;
            tx_sh   <= {desc.opc, desc.addr, desc.wbyte};
            txc     <= d_txc;
            rxf     <= d_rxf;
            last    <= d_rxf + rx_len(desc) - 1'b1;
            use_rx  <= desc.use_rx;
            lanes   <= desc.lanes;
            rx_byte <= '0;
        end else begin
            case (state)
                F_CSON: begin
                    cs_n  <= 1'b0;
                    cyc   <= '0;
                    half  <= 1'b0;
                    state <= F_SHIFT;
                end
                F_SHIFT: begin
                    if (!half) begin
                        sclk <= 1'b1;
                        half <= 1'b1;
                    end else begin
                        sclk  <= 1'b0;
                        half  <= 1'b0;
                        tx_sh <= tx_sh << 1;
                        if (use_rx && cyc >= rxf) rx_byte <= rx_next;
                        if (cyc == last) state <= F_CSOFF;
                        else             cyc   <= cyc + 1'b1;
                    end
                end
                F_CSOFF: begin
                    cs_n  <= 1'b1;
                    state <= F_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign io_out = {3'b000, tx_sh[TX_W-1]};
    assign io_oe  = {3'b000, (state == F_SHIFT) && (cyc < txc)};
    assign done   = (state == F_CSOFF);
    assign idle   = (state == F_IDLE);

    assert_sclk_gate_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_oe_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'b0000));

endmodule

// File: rtl/nor_byte_seq.sv
module nor_byte_seq
    import nor_seq_pkg::*;
#(
    parameter int unsigned DUMMY = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [BUSY_W-1:0] busy,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] stat_data,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    logic              dual_rd, quad_rd, fast_rd, unlocked, incr;
    logic [7:0]        opc_a, opc_b, code_q, plan_code;
    logic [BYTE_W-1:0] wbyte, rx_byte;
    logic [ADDR_W-1:0] addr;
    logic [BUSY_W-1:0] busy_q;
    logic              second_q;
    frame_t            first_f, second_f, eng_desc;
    logic              two_frames, eng_start, eng_done, eng_idle;
    logic              cmd_fire, go_second, fin;

    assign cmd_fire  = cfg_we && (cfg_sel == SEL_CMD) && unlocked &&
                       (busy_q == '0) && is_known_code(cfg_wdata);
    assign plan_code = cmd_fire ? cfg_wdata : code_q;
    assign go_second = eng_done && (busy_q != '0) && !second_q && two_frames;
    assign fin       = eng_done && (busy_q != '0) && (second_q || !two_frames);
    assign eng_start = cmd_fire || go_second;
    assign eng_desc  = cmd_fire ? first_f : second_f;
    assign incr      = fin && (code_q != CODE_STAT);

    nor_seq_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .incr(incr), .dual_rd(dual_rd), .quad_rd(quad_rd), .fast_rd(fast_rd),
        .opc_a(opc_a), .opc_b(opc_b), .wbyte(wbyte), .addr(addr),
        .unlocked(unlocked)
    );

    nor_seq_plan #(.DUMMY(DUMMY)) u_plan (
        .code(plan_code), .dual_rd(dual_rd), .quad_rd(quad_rd),
        .fast_rd(fast_rd), .opc_a(opc_a), .opc_b(opc_b), .addr(addr),
        .wbyte(wbyte), .first_f(first_f), .second_f(second_f),
        .two_frames(two_frames)
    );

    nor_seq_frame u_frame (
        .clk(clk), .rst(rst), .start(eng_start), .desc(eng_desc),
        .io_in(io_in), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .done(eng_done), .idle(eng_idle), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= '0;
            code_q    <= '0;
            second_q  <= 1'b0;
            rd_data   <= '0;
            stat_data <= '0;
        end else begin
            if (cmd_fire) begin
                busy_q <= busy_mask(cfg_wdata);
                code_q <= cfg_wdata;
            end
            if (go_second) second_q <= 1'b1;
            if (fin) begin
                busy_q   <= '0;
                second_q <= 1'b0;
                if (code_q == CODE_PIO_RD) rd_data   <= rx_byte;
                if (code_q == CODE_STAT)   stat_data <= rx_byte;
            end
        end
    end

    assign busy = busy_q;

    assert_busy_track_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q != '0) == !eng_idle);

    assert_key_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q != '0) |-> $past(unlocked));

    assert_rd_source_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data != $past(rd_data)) |-> ($past(fin) && $past(code_q) == CODE_PIO_RD));

    assert_stat_source_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_data != $past(stat_data)) |-> ($past(fin) && $past(code_q) == CODE_STAT));

endmodule

// File: tb/sim_nor_byte_seq.sv
module sim_nor_byte_seq;

    localparam logic [3:0] S_CMD = 4'd0, S_MODE = 4'd1, S_FAST = 4'd2,
                           S_OPA = 4'd3, S_OPB = 4'd4, S_WB = 4'd5,
                           S_A0 = 4'd6, S_A1 = 4'd7, S_A2 = 4'd8, S_KEY = 4'd9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = 4'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [4:0] busy;
    logic [7:0] rd_data, stat_data;
    logic       sclk, cs_n;
    logic [3:0] io_out, io_oe, io_in;

    int checks = 0;
    int errors = 0;
    int glitch = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nor_byte_seq u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .rd_data(rd_data),
        .stat_data(stat_data), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in)
    );

    // behavioural flash
    logic [3:0]  fl_drive = 4'd0;
    int          bc = 0;
    logic [63:0] sh = 64'd0;
    logic [7:0]  fop = 8'd0;
    logic [7:0]  fwb = 8'd0;
    int          faddr = 0;
    bit          wel = 0;
    logic [7:0]  stat_val = 8'd0;
    logic [7:0]  fmem [int];

    assign io_in = fl_drive;

    function automatic logic [7:0] pat(int a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] fl_byte(int a);
        if (fmem.exists(a)) return fmem[a];
        return pat(a);
    endfunction

    always @(posedge sclk) if (!cs_n) begin
        sh = {sh[62:0], io_out[0]};
        bc = bc + 1;
        if (bc == 8)  fop = sh[7:0];
        if (bc == 32) faddr = int'(sh[23:0]);
        if (bc == 40) fwb = sh[7:0];
    end

    always @(negedge sclk) if (!cs_n) begin
        int h, l, g;
        bit rd;
        logic [7:0] d, v;
        rd = 1; h = 0; l = 1;
        case (fop)
            8'h03: begin h = 32; l = 1; end
            8'h0B: begin h = 40; l = 1; end
            8'h3B: begin h = 40; l = 2; end
            8'h6B: begin h = 40; l = 4; end
            8'h05: begin h = 8;  l = 1; end
            default: rd = 0;
        endcase
        if (rd && bc >= h && bc < h + 8 / l) begin
            d = (fop == 8'h05) ? stat_val : fl_byte(faddr);
            g = bc - h;
            v = d >> (8 - l * (g + 1));
            case (l)
                1: fl_drive = {2'b00, v[0], 1'b0};
                2: fl_drive = {2'b00, v[1:0]};
                default: fl_drive = v[3:0];
            endcase
        end
    end

    always @(posedge cs_n) begin
        if (bc == 8 && fop == 8'h06) wel = 1;
        if (bc == 40 && fop == 8'h02 && wel) begin
            fmem[faddr] = fwb;
            wel = 0;
        end
        bc = 0;
    end

    always @(posedge clk) if (!rst && cs_n && sclk) glitch++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setreg(input logic [3:0] s, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_addr(input int a);
        setreg(S_A0, a[7:0]);
        setreg(S_A1, a[15:8]);
        setreg(S_A2, a[23:16]);
    endtask

    // per-cycle busy profile: busy = mask for dur cycles after the write, then 0
    task automatic run_cmd(input logic [7:0] code, input logic [4:0] mask,
                           input int dur, input string req,
                           input int inj_at = -1, input logic [7:0] inj_code = 8'h00);
        int bad;
        int fa, fe;
        bad = 0; fa = 0; fe = 0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = S_CMD; cfg_wdata = code;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int k = 0; k <= dur; k++) begin
            logic [4:0] e;
            e = (k < dur) ? mask : 5'd0;
            if (busy !== e) begin
                if (bad == 0) begin fa = int'(busy); fe = int'(e); end
                bad++;
            end
            if (k == inj_at) begin
                cfg_we = 1'b1; cfg_sel = S_CMD; cfg_wdata = inj_code;
            end else begin
                cfg_we = 1'b0;
            end
            if (k < dur) @(negedge clk);
        end
        cfg_we = 1'b0;
        check(bad == 0, {req, " busy profile"}, fa, fe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 5'd0 && rd_data == 8'd0 && stat_data == 8'd0, "R1 outputs",
              int'({busy, rd_data, stat_data}), 0);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 bus idle", int'({cs_n, sclk}), 2);

        // R2 locked: command ignored
        run_cmd(8'h81, 5'd0, 20, "R2 locked");
        setreg(S_KEY, 8'h30);

        // R4 plain read, R12 selects
        set_addr(32'h012345);
        run_cmd(8'h81, 5'h01, 82, "R4 R3");
        check(rd_data == pat(32'h012345), "R4 R12 plain read", rd_data, pat(32'h012345));

        // R10 auto increment
        run_cmd(8'h81, 5'h01, 82, "R10");
        check(rd_data == pat(32'h012346), "R10 next byte", rd_data, pat(32'h012346));

        // R5 fast read
        setreg(S_FAST, 8'h01);
        setreg(S_OPA, 8'h0B);
        run_cmd(8'h81, 5'h01, 98, "R5");
        check(rd_data == pat(32'h012347), "R5 fast read", rd_data, pat(32'h012347));

        // R6 dual read
        setreg(S_FAST, 8'h00);
        setreg(S_MODE, 8'h01);
        setreg(S_OPA, 8'h3B);
        run_cmd(8'h81, 5'h01, 90, "R6");
        check(rd_data == pat(32'h012348), "R6 dual read", rd_data, pat(32'h012348));

        // R7 quad read with priority and address-mode bits set
        setreg(S_FAST, 8'h01);
        setreg(S_MODE, 8'h0F);
        setreg(S_OPB, 8'h6B);
        run_cmd(8'h81, 5'h01, 86, "R7");
        check(rd_data == pat(32'h012349), "R7 quad read", rd_data, pat(32'h012349));

        // R8 status read
        stat_val = 8'hA6;
        run_cmd(8'h02, 5'h02, 34, "R8");
        check(stat_data == 8'hA6, "R8 status byte", stat_data, 8'hA6);
        check(rd_data == pat(32'h012349), "R8 rd_data held", rd_data, pat(32'h012349));
        setreg(S_MODE, 8'h00);
        setreg(S_FAST, 8'h00);
        run_cmd(8'h81, 5'h01, 82, "R8 R10");
        check(rd_data == pat(32'h01234A), "R8 R10 address held by status", rd_data, pat(32'h01234A));

        // R9 program
        set_addr(32'h000100);
        setreg(S_WB, 8'hC7);
        run_cmd(8'h90, 5'h10, 100, "R9");
        set_addr(32'h000100);
        run_cmd(8'h81, 5'h01, 82, "R9 readback");
        check(rd_data == 8'hC7, "R9 byte programmed", rd_data, 8'hC7);

        // R3 unknown code ignored
        run_cmd(8'h44, 5'd0, 20, "R3 unknown");
        check(rd_data == 8'hC7, "R3 unknown no effect", rd_data, 8'hC7);

        // R3 command while busy ignored
        stat_val = 8'h11;
        set_addr(32'h000200);
        run_cmd(8'h81, 5'h01, 82, "R3 busy", 10, 8'h02);
        check(rd_data == pat(32'h000200), "R3 busy read", rd_data, pat(32'h000200));
        check(stat_data == 8'hA6, "R3 busy status untouched", stat_data, 8'hA6);

        // R10 wrap
        set_addr(32'hFFFFFF);
        run_cmd(8'h81, 5'h01, 82, "R10 top");
        check(rd_data == pat(32'hFFFFFF), "R10 top byte", rd_data, pat(32'hFFFFFF));
        run_cmd(8'h81, 5'h01, 82, "R10 wrap");
        check(rd_data == pat(0), "R10 wrap to zero", rd_data, pat(0));

        // R2 relock
        setreg(S_KEY, 8'h00);
        run_cmd(8'h81, 5'd0, 20, "R2 relocked");
        check(rd_data == pat(0), "R2 relocked no effect", rd_data, pat(0));

        // R11 bus discipline
        check(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 4'd0, "R11 idle bus",
              int'({cs_n, sclk, io_oe}), 32);
        check(glitch == 0, "R11 sclk only in frame", glitch, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule